// File: doc/BRIEF.md
# CAN Bit-Time Timestamp Counter

This block keeps the time base for a CAN controller's time-triggered operation. A 16-bit counter advances by one for every nominal bit time, signalled by a one-cycle strobe from the bit-timing logic. The counter does not advance once per clock.

When the frame logic reports that it sampled a start-of-frame bit, the block copies the counter value into a timestamp register. On the next cycle it raises a one-cycle valid pulse, tagged with the frame direction. A receive FIFO entry or a transmit mailbox latches the timestamp on that pulse.

A single enable bit from the controller's main control register gates the whole function. With the enable clear, time stands still and no frames are stamped.

Top module: `can_bit_timestamp`

## Requirements
- R1: After a synchronous reset, `time_now` is 0, `stamp_value` is 0, `stamp_valid` is 0 and `stamp_dir_tx` is 0.
- R2: While `tt_enable` is 1, every cycle with `bit_strobe` = 1 raises `time_now` by exactly one on the following clock edge. Cycles without a strobe leave it unchanged.
- R3: The counter wraps from 0xFFFF to 0x0000 on a bit strobe, with no flag or other side effect.
- R4: While `tt_enable` is 1, a cycle with `sof_strobe` = 1 loads `stamp_value` with the `time_now` value seen in that cycle. `stamp_valid` is 1 in the cycle after it.
- R5: When `bit_strobe` and `sof_strobe` are both 1 in one enabled cycle, the captured stamp is the count before that increment. The counter still advances.
- R6: `stamp_dir_tx` accompanies each valid pulse with the direction sampled with the start-of-frame: 1 means a transmitted frame and 0 means a received frame.
- R7: `stamp_valid` is high for one cycle per capture. Start-of-frame pulses on consecutive enabled cycles each give their own pulse and their own stamp.
- R8: While `tt_enable` is 0, `time_now` holds its value and start-of-frame pulses produce no valid pulse. `stamp_value` keeps the last captured value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tt_enable | input | 1 | Time-triggered operation enable from the control register |
| bit_strobe | input | 1 | One-cycle pulse per nominal bit time |
| sof_strobe | input | 1 | One-cycle pulse when the start-of-frame bit is sampled |
| sof_dir_tx | input | 1 | Direction of that frame: 1 transmit, 0 receive |
| time_now | output | 16 | Live bit-time counter |
| stamp_value | output | 16 | Last captured timestamp |
| stamp_valid | output | 1 | One-cycle pulse: new timestamp available |
| stamp_dir_tx | output | 1 | Direction tag of the captured timestamp |

## Verification
A bit-time strobe and a start-of-frame pulse can arrive in the same cycle. In that case the capture and the increment happen on one edge.

The bench provokes this on plain counts and again at 0xFFFF. At 0xFFFF the stamp must read 0xFFFF while the counter rolls over to zero. In both cases the scoreboard expects the pre-increment count, and the live counter is compared against a separately advanced model on every cycle.

// File: rtl/can_ts_pkg.sv
package can_ts_pkg;

    localparam int TS_W = 16;

    typedef logic [TS_W-1:0] ts_t;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } frame_dir_e;

    typedef struct packed {
        ts_t        value;
        frame_dir_e dir;
    } stamp_t;

    localparam stamp_t STAMP_RESET = '{value: '0, dir: DIR_RX};

    function automatic ts_t ts_advance(input ts_t cur);
        return cur + ts_t'(1);
    endfunction

endpackage

// File: rtl/can_ts_counter.sv
module can_ts_counter
    import can_ts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output ts_t  count
);

    ts_t count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (run && tick) begin
            count_q <= ts_advance(count_q);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/can_ts_capture.sv
module can_ts_capture
    import can_ts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       sof,
    input  frame_dir_e dir,
    input  ts_t        count,
    output stamp_t     stamp,
    output logic       valid
);

    stamp_t stamp_q;
    logic   valid_q;
    logic   take;

    assign take = run && sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_q <= STAMP_RESET;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) begin
                stamp_q <= '{value: count, dir: dir};
            end
        end
    end

    assign stamp = stamp_q;
    assign valid = valid_q;

endmodule

// File: rtl/can_bit_timestamp.sv
module can_bit_timestamp
    import can_ts_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tt_enable,
    input  logic            bit_strobe,
    input  logic            sof_strobe,
    input  logic            sof_dir_tx,
    output logic [TS_W-1:0] time_now,
    output logic [TS_W-1:0] stamp_value,
    output logic            stamp_valid,
    output logic            stamp_dir_tx
);

    ts_t        cnt;
    stamp_t     stamp;
    frame_dir_e dir_in;

    assign dir_in = sof_dir_tx ? DIR_TX : DIR_RX;

    can_ts_counter u_counter (
        .clk   (clk),
        .rst   (rst),
        .run   (tt_enable),
        .tick  (bit_strobe),
        .count (cnt)
    );

    can_ts_capture u_capture (
        .clk   (clk),
        .rst   (rst),
        .run   (tt_enable),
        .sof   (sof_strobe),
        .dir   (dir_in),
        .count (cnt),
        .stamp (stamp),
        .valid (stamp_valid)
    );

    assign time_now     = cnt;
    assign stamp_value  = stamp.value;
    assign stamp_dir_tx = (stamp.dir == DIR_TX);

endmodule

// File: rtl/can_bit_timestamp_chk.sv
module can_bit_timestamp_chk
    import can_ts_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            tt_enable,
    input logic            bit_strobe,
    input logic            sof_strobe,
    input logic            sof_dir_tx,
    input logic [TS_W-1:0] time_now,
    input logic [TS_W-1:0] stamp_value,
    input logic            stamp_valid,
    input logic            stamp_dir_tx
);

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (tt_enable && bit_strobe) |=> (time_now == ts_t'($past(time_now) + 1'b1))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (tt_enable && !bit_strobe) |=> $stable(time_now)); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tt_enable && bit_strobe && time_now == '1) |=> (time_now == '0)); // R3

    AST_STAMP_PRE_INC: assert property (@(posedge clk) disable iff (rst)
        (tt_enable && sof_strobe) |=> (stamp_valid && stamp_value == $past(time_now))); // R4

    AST_DIR_TAG: assert property (@(posedge clk) disable iff (rst)
        (tt_enable && sof_strobe) |=> (stamp_dir_tx == $past(sof_dir_tx))); // R6

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !(tt_enable && sof_strobe) |=> !stamp_valid); // R7

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !tt_enable |=> ($stable(time_now) && $stable(stamp_value))); // R8

endmodule

bind can_bit_timestamp can_bit_timestamp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tt_enable    (tt_enable),
    .bit_strobe   (bit_strobe),
    .sof_strobe   (sof_strobe),
    .sof_dir_tx   (sof_dir_tx),
    .time_now     (time_now),
    .stamp_value  (stamp_value),
    .stamp_valid  (stamp_valid),
    .stamp_dir_tx (stamp_dir_tx)
);

// File: tb/can_bit_timestamp_bench.sv
module can_bit_timestamp_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tt_enable = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        sof_strobe = 1'b0;
    logic        sof_dir_tx = 1'b0;
    logic [15:0] time_now;
    logic [15:0] stamp_value;
    logic        stamp_valid;
    logic        stamp_dir_tx;

    always #4 clk = ~clk;

    can_bit_timestamp u_can_bit_timestamp (
        .clk          (clk),
        .rst          (rst),
        .tt_enable    (tt_enable),
        .bit_strobe   (bit_strobe),
        .sof_strobe   (sof_strobe),
        .sof_dir_tx   (sof_dir_tx),
        .time_now     (time_now),
        .stamp_value  (stamp_value),
        .stamp_valid  (stamp_valid),
        .stamp_dir_tx (stamp_dir_tx)
    );

    typedef struct {
        logic [15:0] value;
        logic        tx;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] model_cnt  = 16'h0;
    logic [15:0] last_stamp = 16'h0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          mon_on = 1'b0;
    string       cnt_req = "R2";
    bit          done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // driver: one cycle of stimulus, expectations pushed to the scoreboard
    task automatic drive(input bit en, input bit tick, input bit sof, input bit tx);
        @(negedge clk);
        tt_enable  = en;
        bit_strobe = tick;
        sof_strobe = sof;
        sof_dir_tx = tx;
        if (en && sof) sb_q.push_back('{value: model_cnt, tx: tx, req: (tick ? "R5" : "R4")});
        if (en && tick) model_cnt = model_cnt + 16'h1;
    endtask

    // monitor: compares after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (mon_on) begin
            check(time_now == model_cnt, cnt_req, "time_now", 32'(time_now), 32'(model_cnt));
            if (stamp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected stamp_valid", 32'(stamp_valid), 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(stamp_value == e.value, e.req, "stamp_value",
                          32'(stamp_value), 32'(e.value));
                    check(stamp_dir_tx == e.tx, "R6", "stamp_dir_tx",
                          32'(stamp_dir_tx), 32'(e.tx));
                    last_stamp = e.value;
                end
            end else begin
                if (sb_q.size() != 0) begin
                    check(1'b0, "R4", "missing stamp_valid", 32'(stamp_valid), 32'h1);
                    void'(sb_q.pop_front());
                end
                check(stamp_value == last_stamp, "R8", "stamp_value held",
                      32'(stamp_value), 32'(last_stamp));
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "WDOG", "watchdog expired", 32'h0, 32'h1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        // R1: reset state
        check(time_now == 16'h0, "R1", "time_now", 32'(time_now), 32'h0);
        check(stamp_value == 16'h0, "R1", "stamp_value", 32'(stamp_value), 32'h0);
        check(stamp_valid == 1'b0, "R1", "stamp_valid", 32'(stamp_valid), 32'h0);
        check(stamp_dir_tx == 1'b0, "R1", "stamp_dir_tx", 32'(stamp_dir_tx), 32'h0);
        mon_on = 1'b1;

        // R2: counting with gaps
        for (int i = 0; i < 20; i++) drive(1, (i % 3) != 1, 0, 0);
        // R4 / R6: received and transmitted frames, counter idle
        drive(1, 0, 1, 0);
        drive(1, 1, 0, 0);
        drive(1, 0, 1, 1);
        drive(1, 1, 0, 0);
        // R5: tick and start-of-frame together
        drive(1, 1, 1, 1);
        drive(1, 1, 1, 0);
        drive(1, 0, 0, 0);
        // R7: back-to-back captures
        drive(1, 1, 1, 0);
        drive(1, 0, 1, 1);
        drive(1, 1, 1, 1);
        drive(1, 0, 0, 0);
        drive(1, 0, 0, 0);
        // R8: disabled; strobes and frames ignored, values held
        cnt_req = "R8";
        for (int i = 0; i < 10; i++) drive(0, 1, (i % 2) == 0, i[0]);
        drive(1, 0, 0, 0);
        // R3: run up to 0xFFFF, capture with a tick there, then wrap
        cnt_req = "R2";
        while (model_cnt != 16'hFFFF) drive(1, 1, 0, 0);
        cnt_req = "R3";
        drive(1, 1, 1, 1);
        drive(1, 1, 0, 0);
        drive(1, 0, 1, 0);
        drive(1, 0, 0, 0);
        drive(0, 0, 0, 0);
        @(posedge clk);
        #3;
        check(sb_q.size() == 0, "R4", "scoreboard drained", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        finish_run();
    end

endmodule